// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block models a single-port synchronous static RAM. Reads and writes can follow one another on every clock with no idle cycle between them. A command is captured on a rising clock edge. Its data uses the shared bidirectional bus at the second edge after that. This holds for both kinds of access: read data is driven from a pipeline output register, and write data is sampled from the bus. Because reads and writes use the same schedule, one command can be issued per cycle in any mix and the bus never has two drivers.

Words are built from 9-bit lanes, each holding 8 data bits and 1 parity bit. There are two lanes at 18 bits and four lanes at 36 bits. Each lane has its own active-low write enable. A load command starts a burst and an advance command steps a 2-bit counter. The counter's order is either modulo-4 addition or XOR, chosen by a pin. Three chip selects of mixed polarity allow several devices to share one bus for depth expansion. The output enable acts on the bus drivers without waiting for a clock. The sleep input freezes the whole device and keeps its contents.

The data bus follows a fixed schedule that both sides know. It therefore has no valid/ready handshake and cannot apply back-pressure. The controller must present write data exactly in its slot. Every other pin is a plain control level sampled at the clock edge.

Top module: `pipe_sram`

## Requirements
- R1: A read command captured at edge k drives its word onto `dq` from just after edge k+1 until edge k+2. A master samples it at edge k+2.
- R2: For a write command captured at edge k, the word is taken from `dq` at edge k+2. The block never drives `dq` in that slot, so read and write commands may alternate on every cycle.
- R3: When `lin_order`=1, beat n of a burst (n=0..3, then wrapping) uses address low bits (base[1:0] + n) mod 4. The upper address bits stay fixed.
- R4: When `lin_order`=0, beat n uses address low bits base[1:0] XOR n.
- R5: `adv`=1 repeats the cycle type of the last load on the next burst address. It is a no-op when no burst is active: after reset, or after a load that was not selected.
- R6: Lane i is `dq[9i+8:9i]`, and its enable is `lane_wr_n[i]` (active low). A write changes only lanes whose enable is 0. Reads ignore the enables.
- R7: A write with every lane enable at 1 is aborted and leaves the memory unchanged.
- R8: A load is selected only when `sel1_n`=0, `sel2`=1 and `sel3_n`=0. Otherwise the cycle is a deselect: no drive, no write, and the burst ends.
- R9: `oe_n`=1 releases `dq` combinationally without disturbing the pipeline. Returning it to 0 shows the same read word again.
- R10: While `sleep`=1, commands are ignored, every pipeline stage holds its value, and `dq` is released. After `sleep` returns to 0, pending accesses finish on their schedule.
- R11: A read of an address whose earlier write has not yet reached the array returns the newer data, merged lane by lane with the write's enables.
- R12: After reset, no burst is active and `dq` is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything captures on the rising edge |
| rst_n | input | 1 | Active-low reset of pipeline and burst state |
| sleep | input | 1 | High freezes the device and releases the bus |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| adv | input | 1 | 0 loads a new command, 1 advances the burst |
| we_n | input | 1 | 0 write, 1 read (sampled on load) |
| lane_wr_n | input | W/9 | Per-lane write enables, active low |
| addr | input | log2(DEPTH) | Word address (sampled on load) |
| lin_order | input | 1 | 1 linear burst order, 0 interleaved |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| dq | inout | W | Shared bidirectional data bus |

## Verification
Each result has a fixed due point counted in awake edges after its command edge. Read data is due on `dq` at the second edge. Write data is consumed at the second edge. Its effect shows in the next read of that address, whatever the gap. The bench keeps a four-entry ring of issued commands and compares `dq` on the falling edge just before each due edge. It releases its own drivers before each comparison and drives write data only after it. Sleep edges do not advance the schedule. The output-enable check toggles `oe_n` in mid-cycle and samples within the same half cycle.

// File: rtl/psram_pkg.sv
package psram_pkg;
  localparam int LANE_W = 9;

  // low two address bits of burst beat n
  function automatic logic [1:0] beat_lo(input logic [1:0] base,
                                         input logic [1:0] n,
                                         input logic       lin);
    return lin ? (base + n) : (base ^ n);
  endfunction
endpackage

// File: rtl/psram_seq.sv
module psram_seq #(
  parameter int AW    = 6,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             sel_ok,
  input  logic             adv,
  input  logic             we_n,
  input  logic             lin,
  input  logic [AW-1:0]    addr,
  input  logic [LANES-1:0] lane_n,
  output logic             c_vld,
  output logic             c_wr,
  output logic [AW-1:0]    c_addr,
  output logic [LANES-1:0] c_lane_n
);
  import psram_pkg::*;

  logic          run;
  logic          run_wr;
  logic [AW-1:0] base;
  logic [1:0]    cnt;
  logic [1:0]    cnt_nx;

  assign cnt_nx = cnt + 2'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run      <= 1'b0;
      run_wr   <= 1'b0;
      base     <= '0;
      cnt      <= '0;
      c_vld    <= 1'b0;
      c_wr     <= 1'b0;
      c_addr   <= '0;
      c_lane_n <= '1;
    end else if (!hold) begin
      c_lane_n <= lane_n;
      if (!adv) begin
        if (sel_ok) begin
          run    <= 1'b1;
          run_wr <= ~we_n;
          base   <= addr;
          cnt    <= 2'd0;
          c_vld  <= 1'b1;
          c_wr   <= ~we_n;
          c_addr <= addr;
        end else begin
          run   <= 1'b0;
          c_vld <= 1'b0;
        end
      end else if (run) begin
        cnt    <= cnt_nx;
        c_vld  <= 1'b1;
        c_wr   <= run_wr;
        c_addr <= {base[AW-1:2], beat_lo(base[1:0], cnt_nx, lin)};
      end else begin
        c_vld <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/psram_array.sv
module psram_array #(
  parameter int DEPTH = 64,
  parameter int LANES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  hold,
  input  logic                  s1_vld,
  input  logic                  s1_wr,
  input  logic [$clog2(DEPTH)-1:0] s1_addr,
  input  logic [LANES-1:0]      s1_lane_n,
  input  logic [LANES*9-1:0]    bus_in,
  output logic [LANES*9-1:0]    rd_q,
  output logic                  rd_on
);
  import psram_pkg::*;
  localparam int AW = $clog2(DEPTH);
  localparam int W  = LANES * LANE_W;

  logic             s2_vld, s2_wr;
  logic [AW-1:0]    s2_addr;
  logic [LANES-1:0] s2_lane_n;
  logic             s3_vld;
  logic [AW-1:0]    s3_addr;
  logic [LANES-1:0] s3_lane_n;
  logic [W-1:0]     s3_data;
  logic [W-1:0]     merged;
  logic             hit2, hit3;

  assign hit2 = s2_vld && s2_wr && (s2_addr == s1_addr);
  assign hit3 = s3_vld && (s3_addr == s1_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_vld    <= 1'b0;
      s2_wr     <= 1'b0;
      s2_addr   <= '0;
      s2_lane_n <= '1;
      s3_vld    <= 1'b0;
      s3_addr   <= '0;
      s3_lane_n <= '1;
      s3_data   <= '0;
      rd_on     <= 1'b0;
      rd_q      <= '0;
    end else if (!hold) begin
      s2_vld    <= s1_vld;
      s2_wr     <= s1_wr;
      s2_addr   <= s1_addr;
      s2_lane_n <= s1_lane_n;
      s3_vld    <= s2_vld && s2_wr;
      s3_addr   <= s2_addr;
      s3_lane_n <= s2_lane_n;
      s3_data   <= bus_in;
      rd_on     <= s1_vld && !s1_wr;
      rd_q      <= merged;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];
    logic [LANE_W-1:0] lane_rd;

    always_ff @(posedge clk) begin
      if (!hold && s3_vld && !s3_lane_n[g])
        store[s3_addr] <= s3_data[g*LANE_W +: LANE_W];
    end

    // newest pending write wins: stage 2 (on the bus now) over stage 3
    always_comb begin
      lane_rd = store[s1_addr];
      if (hit3 && !s3_lane_n[g]) lane_rd = s3_data[g*LANE_W +: LANE_W];
      if (hit2 && !s2_lane_n[g]) lane_rd = bus_in[g*LANE_W +: LANE_W];
    end

    assign merged[g*LANE_W +: LANE_W] = lane_rd;
  end
endmodule

// File: rtl/pipe_sram.sv
module pipe_sram #(
  parameter int W     = 18,
  parameter int DEPTH = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sleep,
  input  logic                     sel1_n,
  input  logic                     sel2,
  input  logic                     sel3_n,
  input  logic                     adv,
  input  logic                     we_n,
  input  logic [W/9-1:0]           lane_wr_n,
  input  logic [$clog2(DEPTH)-1:0] addr,
  input  logic                     lin_order,
  input  logic                     oe_n,
  inout  wire  [W-1:0]             dq
);
  import psram_pkg::*;
  localparam int LANES = W / LANE_W;
  localparam int AW    = $clog2(DEPTH);

  logic             sel_ok;
  logic             c_vld, c_wr;
  logic [AW-1:0]    c_addr;
  logic [LANES-1:0] c_lane_n;
  logic [W-1:0]     rd_q;
  logic             rd_on;
  logic             drive;

  assign sel_ok = ~sel1_n & sel2 & ~sel3_n;

  psram_seq #(.AW(AW), .LANES(LANES)) u_seq (
    .clk(clk), .rst_n(rst_n), .hold(sleep), .sel_ok(sel_ok),
    .adv(adv), .we_n(we_n), .lin(lin_order), .addr(addr),
    .lane_n(lane_wr_n), .c_vld(c_vld), .c_wr(c_wr),
    .c_addr(c_addr), .c_lane_n(c_lane_n)
  );

  psram_array #(.DEPTH(DEPTH), .LANES(LANES)) u_arr (
    .clk(clk), .rst_n(rst_n), .hold(sleep),
    .s1_vld(c_vld), .s1_wr(c_wr), .s1_addr(c_addr), .s1_lane_n(c_lane_n),
    .bus_in(dq), .rd_q(rd_q), .rd_on(rd_on)
  );

  assign drive = rd_on & ~oe_n & ~sleep;
  assign dq    = drive ? rd_q : {W{1'bz}};
endmodule

// File: rtl/psram_chk.sv
module psram_chk #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst_n,
  input logic         sleep,
  input logic         sel1_n,
  input logic         sel2,
  input logic         sel3_n,
  input logic         adv,
  input logic         we_n,
  input logic         rd_on,
  input logic [W-1:0] rd_q
);
  logic [1:0] up;
  logic       sel_in, ld_rd, ld_wr, ld_off;

  always_ff @(posedge clk) begin
    if (!rst_n) up <= 2'd0;
    else if (up != 2'd3) up <= up + 2'd1;
  end

  assign sel_in = !sel1_n && sel2 && !sel3_n;
  assign ld_rd  = !sleep && !adv && sel_in && we_n;
  assign ld_wr  = !sleep && !adv && sel_in && !we_n;
  assign ld_off = !sleep && !adv && !sel_in;

  // R1: a loaded read owns the bus slot two awake edges later
  assert_rd_slot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (up >= 2'd2 && $past(ld_rd, 2) && $past(!sleep, 1)) |-> rd_on);

  // R2: a loaded write slot is never driven by the block
  assert_wr_slot_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (up >= 2'd2 && $past(ld_wr, 2) && $past(!sleep, 1)) |-> !rd_on);

  // R8: a deselected load produces no read slot
  assert_desel_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (up >= 2'd2 && $past(ld_off, 2) && $past(!sleep, 1)) |-> !rd_on);

  // R10: pipeline output state is frozen across a sleep edge
  assert_sleep_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> ($stable(rd_on) && $stable(rd_q)));
endmodule

bind pipe_sram psram_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep(sleep), .sel1_n(sel1_n), .sel2(sel2),
  .sel3_n(sel3_n), .adv(adv), .we_n(we_n), .rd_on(rd_on), .rd_q(rd_q)
);

// File: tb/pipe_sram_tb.sv
module pipe_sram_tb;
  localparam int W = 18;
  localparam int DEPTH = 64;
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic clk = 1'b0;
  logic rst_n, sleep, sel1_n, sel2, sel3_n, adv, we_n, lin, oe_n;
  logic [1:0] ben_n;
  logic [5:0] addr;
  logic [W-1:0] tb_dq;
  logic tb_drv;
  tri1 [W-1:0] dq;

  assign dq = tb_drv ? tb_dq : {W{1'bz}};
  always #10 clk = ~clk;

  pipe_sram #(.W(W), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .sel1_n(sel1_n), .sel2(sel2),
    .sel3_n(sel3_n), .adv(adv), .we_n(we_n), .lane_wr_n(ben_n), .addr(addr),
    .lin_order(lin), .oe_n(oe_n), .dq(dq)
  );

  int checks = 0;
  int fails = 0;
  int t = 0;
  string req = "R12";

  logic [W-1:0] mm [DEPTH];
  logic m_on, m_wr;
  logic [5:0] m_base;
  logic [1:0] m_cnt;
  logic r_v [4], r_w [4], r_oe [4];
  logic [W-1:0] r_d [4];

  task automatic chk(input string r, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: dq=%h expected %h (cycle %0d)", r, act, exp, t);
    end
  endtask

  function automatic logic [W-1:0] nz(input logic [W-1:0] x);
    return (x == ONES) ? (x ^ 18'h1) : x;
  endfunction

  // ce bits: {sel1_n, ~sel2, sel3_n}; 0 means selected
  task automatic cyc(input logic ld_n, input logic w_n, input logic [5:0] a,
                     input logic [1:0] be, input logic l, input logic [2:0] ce,
                     input logic probe);
    int s, n;
    logic v, w;
    logic [5:0] ea;
    logic [W-1:0] d;
    @(negedge clk);
    tb_drv = 1'b0;
    sleep = 1'b0;
    #1;
    s = (t + 2) % 4;
    if (r_v[s] && !r_w[s]) begin
      if (r_oe[s]) begin
        oe_n = 1'b1; #1;
        chk({req, " R9 released"}, dq, ONES);
        oe_n = 1'b0; #1;
      end
      chk(req, dq, r_d[s]);
    end else if (!(r_v[s] && r_w[s])) begin
      chk({req, " idle slot"}, dq, ONES);
    end
    if (r_v[s] && r_w[s]) begin
      tb_dq = r_d[s];
      tb_drv = 1'b1;
    end
    adv = ld_n; we_n = w_n; addr = a; ben_n = be; lin = l;
    sel1_n = ce[2]; sel2 = ~ce[1]; sel3_n = ce[0];
    v = 1'b0; ea = a;
    if (!ld_n) begin
      if (ce == 3'b000) begin
        m_on = 1'b1; m_wr = ~w_n; m_base = a; m_cnt = 2'd0; v = 1'b1;
      end else m_on = 1'b0;
    end else if (m_on) begin
      m_cnt = m_cnt + 2'd1;
      v = 1'b1;
      ea = {m_base[5:2], l ? (m_base[1:0] + m_cnt) : (m_base[1:0] ^ m_cnt)};
    end
    w = m_wr;
    n = t % 4;
    r_v[n] = v; r_w[n] = w; r_oe[n] = probe;
    if (v && w) begin
      d = nz(W'($urandom));
      for (int k = 0; k < 2; k++)
        if (!be[k]) mm[ea][k*9 +: 9] = d[k*9 +: 9];
      r_d[n] = d;
    end else if (v) begin
      r_d[n] = mm[ea];
    end
    @(posedge clk);
    t++;
  endtask

  task automatic nap(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      tb_drv = 1'b0;
      sleep = 1'b1;
      adv = 1'($urandom); we_n = 1'($urandom); addr = 6'($urandom);
      ben_n = 2'($urandom); sel1_n = 1'b0; sel2 = 1'b1; sel3_n = 1'b0;
      #1;
      chk("R10 asleep bus", dq, ONES);
      @(posedge clk);
    end
  endtask

  task automatic idle();
    cyc(1'b0, 1'b1, 6'd0, 2'b11, 1'b1, 3'b111, 1'b0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 4; i++) begin r_v[i] = 1'b0; r_w[i] = 1'b0; r_oe[i] = 1'b0; r_d[i] = '0; end
    m_on = 1'b0; m_wr = 1'b0; m_base = '0; m_cnt = '0;
    rst_n = 1'b0; sleep = 1'b0; sel1_n = 1'b1; sel2 = 1'b0; sel3_n = 1'b1;
    adv = 1'b1; we_n = 1'b1; lin = 1'b1; oe_n = 1'b0; ben_n = 2'b11; addr = '0;
    tb_drv = 1'b0; tb_dq = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk("R12 reset bus", dq, ONES);
    rst_n = 1'b1;

    // R12 / R5: advance with no burst after reset does nothing
    req = "R5 advance after reset";
    repeat (3) cyc(1'b1, 1'b1, 6'd5, 2'b00, 1'b1, 3'b000, 1'b0);

    req = "R2 fill";
    for (int a = 0; a < DEPTH; a++) cyc(1'b0, 1'b0, 6'(a), 2'b00, 1'b1, 3'b000, 1'b0);
    req = "R1 readback";
    for (int a = 0; a < DEPTH; a++) cyc(1'b0, 1'b1, 6'(a), 2'b00, 1'b1, 3'b000, 1'b0);

    req = "R2 alternate";
    for (int i = 0; i < 16; i++) begin
      cyc(1'b0, 1'b0, 6'(i), 2'b00, 1'b1, 3'b000, 1'b0);
      cyc(1'b0, 1'b1, 6'(i + 32), 2'b11, 1'b1, 3'b000, 1'b0);
    end

    req = "R3 linear";
    for (int b = 0; b < 4; b++) begin
      cyc(1'b0, 1'b0, 6'(16 + b), 2'b00, 1'b1, 3'b000, 1'b0);
      repeat (4) cyc(1'b1, 1'b1, 6'd0, 2'b00, 1'b1, 3'b000, 1'b0);
      cyc(1'b0, 1'b1, 6'(16 + b), 2'b00, 1'b1, 3'b000, 1'b0);
      repeat (5) cyc(1'b1, 1'b0, 6'd0, 2'b00, 1'b1, 3'b000, 1'b0);
    end
    req = "R4 interleaved";
    for (int b = 0; b < 4; b++) begin
      cyc(1'b0, 1'b0, 6'(24 + b), 2'b00, 1'b0, 3'b000, 1'b0);
      repeat (3) cyc(1'b1, 1'b1, 6'd0, 2'b00, 1'b0, 3'b000, 1'b0);
      cyc(1'b0, 1'b1, 6'(24 + b), 2'b00, 1'b0, 3'b000, 1'b0);
      repeat (4) cyc(1'b1, 1'b0, 6'd0, 2'b00, 1'b0, 3'b000, 1'b0);
    end

    req = "R6 lanes";
    for (int a = 40; a < 44; a++) begin
      cyc(1'b0, 1'b0, 6'(a), 2'b10, 1'b1, 3'b000, 1'b0);
      cyc(1'b0, 1'b0, 6'(a + 4), 2'b01, 1'b1, 3'b000, 1'b0);
    end
    for (int a = 40; a < 48; a++) cyc(1'b0, 1'b1, 6'(a), 2'($urandom), 1'b1, 3'b000, 1'b0);

    req = "R7 abort";
    for (int a = 50; a < 54; a++) cyc(1'b0, 1'b0, 6'(a), 2'b11, 1'b1, 3'b000, 1'b0);
    for (int a = 50; a < 54; a++) cyc(1'b0, 1'b1, 6'(a), 2'b00, 1'b1, 3'b000, 1'b0);

    req = "R11 forward";
    for (int i = 0; i < 6; i++) begin
      cyc(1'b0, 1'b0, 6'd60, 2'(i % 3), 1'b1, 3'b000, 1'b0);
      cyc(1'b0, 1'b1, 6'd60, 2'b00, 1'b1, 3'b000, 1'b0);
      cyc(1'b0, 1'b1, 6'd60, 2'b00, 1'b1, 3'b000, 1'b0);
    end

    req = "R8 deselect";
    for (int c = 0; c < 3; c++) begin
      cyc(1'b0, 1'b0, 6'd61, 2'b00, 1'b1, 3'(1 << c), 1'b0);
      cyc(1'b1, 1'b1, 6'd0, 2'b00, 1'b1, 3'b000, 1'b0);
      cyc(1'b0, 1'b1, 6'd61, 2'b00, 1'b1, 3'(1 << c), 1'b0);
      cyc(1'b0, 1'b1, 6'd61, 2'b00, 1'b1, 3'b000, 1'b0);
    end

    req = "R9 output enable";
    for (int a = 0; a < 4; a++) cyc(1'b0, 1'b1, 6'(a), 2'b00, 1'b1, 3'b000, 1'b1);

    req = "R10 wake";
    cyc(1'b0, 1'b0, 6'd62, 2'b00, 1'b1, 3'b000, 1'b0);
    nap(3);
    cyc(1'b0, 1'b1, 6'd62, 2'b00, 1'b1, 3'b000, 1'b0);
    nap(2);
    cyc(1'b0, 1'b1, 6'd63, 2'b00, 1'b1, 3'b000, 1'b0);
    nap(1);
    idle();
    nap(2);
    idle();

    req = "R6 random";
    for (int i = 0; i < 2000; i++) begin
      if ($urandom % 16 == 0) nap(1 + int'($urandom % 3));
      else cyc(($urandom % 4) != 0, 1'($urandom), 6'($urandom % 8),
               2'($urandom), 1'($urandom),
               (($urandom % 8) == 0) ? 3'(1 << ($urandom % 3)) : 3'b000,
               ($urandom % 8) == 0);
    end
    req = "R1 drain";
    repeat (4) idle();
    finish_run();
  end
endmodule